// File: doc/BRIEF.md
# Spare Memory Module Failover Controller

This block supervises a memory system built from several channels, each with a fixed number of module slots. When sparing is switched on, the last slot of every channel holds a reserve module that is kept out of the normal address map. The controller counts runtime errors for every module. When a primary module's count rises above a programmable threshold, it starts a one-time background migration. The contents of the failing slot are copied into the reserve slot of the same channel. This happens in every channel where that slot is populated, so the failing module and its partner in the other channel move together.

The copy advances one word each time the memory controller grants a slot, interleaved with normal traffic. While the copy runs, normal writes to the failing slot in any copied channel are also sent to that channel's reserve, so the reserve never goes stale. Normal reads stay on the failing module until the very last word has been copied. From then on, requests to the failing slot are steered to the reserve and the failing module is retired. This remap is permanent: no further failover can start until reset.

Module indices are flat: module `m` sits in channel `m / SLOTS` at slot `m % SLOTS`. The size code of module `m` sits in bits `m*SZ_W +: SZ_W` of `sizeCodes`. A code `s` means the module holds 2^s words.

Top module: `spare_failover`

## Requirements
- R1: After reset the state reads IDLE (`stateOut` = 0), `copyReq` is low, `copyAddr` and `failMod` are 0, `cfgErr` is low and every error counter is zero.
- R2: While sparing is active, a valid request whose slot is `SLOTS-1` raises `reqHole`. While sparing is inactive, `reqHole` stays low for every module.
- R3: One cycle after `cfgSpareEn` is high, `cfgErr` reads 1 if any channel's reserve slot is unpopulated or has a smaller size code than the largest populated primary module. In that case sparing stays inactive and no error count can start a copy.
- R4: Each error report adds one to that module's saturating counter. A populated primary module whose count is strictly greater than `cfgThresh` starts the copy while the controller is IDLE and sparing is active. The state reads COPYING (1) one cycle after the count changes, and `failMod` shows the module index. When several modules are over the threshold, the lowest index wins.
- R5: In COPYING, `copyReq` is high and `copyAddr` starts at 0 and advances by one on each cycle with `copyGnt` high. The copy covers 2^k words, where k is the largest size code among the copied modules. Bit c of `copySrcMask` is set when channel c's failing slot is populated.
- R6: During COPYING, a valid write to the failing slot in a channel whose `copySrcMask` bit is set raises `reqMirror`, and `reqMirrorMod` names that channel's reserve module. Reads and other modules are never mirrored. This includes a write in the same cycle as the final grant.
- R7: Until the final grant, requests keep `reqPhysMod` equal to `reqMod`. From the cycle after the final grant, the state reads SPARED (2), `copyReq` falls, and requests to the failing slot in any channel map to that channel's reserve module.
- R8: Once a copy has started, further threshold crossings neither start another copy nor change `failMod`. SPARED holds until reset.
- R9: With `cfgSpareEn` low, every module is visible and no error count starts a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSpareEn | input | 1 | Request to hold the reserve slots out of the map |
| cfgThresh | input | CNT_W | Error count that must be exceeded |
| popMask | input | NMOD | Bit m set when module m is installed |
| sizeCodes | input | NMOD*SZ_W | Log2 word count per module |
| errValid | input | 1 | An error report is present |
| errMod | input | MOD_W | Module the error belongs to |
| reqValid | input | 1 | Normal request present |
| reqWrite | input | 1 | Request is a write |
| reqMod | input | MOD_W | Logical module addressed |
| reqPhysMod | output | MOD_W | Physical module to access |
| reqHole | output | 1 | Request targets a hidden reserve slot |
| reqMirror | output | 1 | Also write the reserve module |
| reqMirrorMod | output | MOD_W | Reserve module for the mirrored write |
| copyReq | output | 1 | Copy engine wants a slot |
| copyGnt | input | 1 | Slot granted for one copy word |
| copyAddr | output | ADDR_W | Word being copied |
| copySrcMask | output | NUM_CH | Channels taking part in the copy |
| stateOut | output | 2 | 0 IDLE, 1 COPYING, 2 SPARED |
| failMod | output | MOD_W | Index of the failed module |
| cfgErr | output | 1 | Sparing requested with an unusable reserve |

## Verification
The delicate collision is a normal write to the failing slot that lands in the same cycle as the final copy grant. That write is handled in the COPYING state, so it must still be mirrored into the reserve, even though the remap takes effect on the following edge. The bench provokes this by raising the last grant and a write to the failing module on one clock. It expects `reqMirror` high with the reserve index, and in the next cycle it expects SPARED with the failing slot steered to the reserve. A second overlap is an error stream that crosses the threshold on another module while the copy is under way. The bench checks that `failMod` and the copy progress stay unchanged.

// File: rtl/spare_pkg.sv
package spare_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COPY   = 2'd1,
    ST_SPARED = 2'd2
  } spState_e;

  typedef struct packed {
    logic startCopy;
    logic copyStep;
    logic copying;
    logic spared;
  } ctrlStrobe_t;

endpackage

// File: rtl/spare_ctrl.sv
module spare_ctrl
  import spare_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        active,
  input  logic        hit,
  input  logic        copyGnt,
  input  logic        copyLast,
  output ctrlStrobe_t strb,
  output logic [1:0]  stateOut
);

  spState_e stQ, stD;

  always_comb begin
    stD = stQ;
    strb = '0;
    strb.copying = (stQ == ST_COPY);
    strb.spared  = (stQ == ST_SPARED);
    unique case (stQ)
      ST_IDLE: begin
        if (active && hit) begin
          strb.startCopy = 1'b1;
          stD = ST_COPY;
        end
      end
      ST_COPY: begin
        if (copyGnt) begin
          if (copyLast) stD = ST_SPARED;
          else strb.copyStep = 1'b1;
        end
      end
      ST_SPARED: stD = ST_SPARED;
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  assign stateOut = stQ;

  // R8: the remap is permanent
  a_r8_spared_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_SPARED) |=> (stQ == ST_SPARED));

  // R7: copying only ends on the final granted word
  a_r7_copy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_COPY && !(copyGnt && copyLast)) |=> (stQ == ST_COPY));

  // R3, R9: no start while sparing is inactive
  a_r9_no_start_inactive: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_IDLE && !active) |=> (stQ == ST_IDLE));

endmodule

// File: rtl/spare_dp.sv
module spare_dp
  import spare_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int SLOTS  = 3,
  parameter int CNT_W  = 4,
  parameter int SZ_W   = 3,
  localparam int NMOD   = NUM_CH * SLOTS,
  localparam int MOD_W  = (NMOD > 1) ? $clog2(NMOD) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int ADDR_W = (1 << SZ_W) - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strb,
  input  logic                 cfgSpareEn,
  input  logic [CNT_W-1:0]     cfgThresh,
  input  logic [NMOD-1:0]      popMask,
  input  logic [NMOD*SZ_W-1:0] sizeCodes,
  input  logic                 errValid,
  input  logic [MOD_W-1:0]     errMod,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [MOD_W-1:0]     reqMod,
  output logic [MOD_W-1:0]     reqPhysMod,
  output logic                 reqHole,
  output logic                 reqMirror,
  output logic [MOD_W-1:0]     reqMirrorMod,
  output logic [ADDR_W-1:0]    copyAddr,
  output logic [NUM_CH-1:0]    copySrcMask,
  output logic [MOD_W-1:0]     failMod,
  output logic                 cfgErr,
  output logic                 active,
  output logic                 hit,
  output logic                 copyLast
);

  // ---------------- configuration check ----------------
  logic [SZ_W-1:0] maxPrim;
  logic            cfgBad;
  logic            cfgErrQ, activeQ;

  always_comb begin
    maxPrim = '0;
    cfgBad  = 1'b0;
    for (int m = 0; m < NMOD; m++) begin
      if (popMask[m] && ((m % SLOTS) != SLOTS - 1) &&
          (sizeCodes[m*SZ_W +: SZ_W] > maxPrim))
        maxPrim = sizeCodes[m*SZ_W +: SZ_W];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (!popMask[c*SLOTS + SLOTS - 1] ||
          (sizeCodes[(c*SLOTS + SLOTS - 1)*SZ_W +: SZ_W] < maxPrim))
        cfgBad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgErrQ <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      cfgErrQ <= cfgSpareEn & cfgBad;
      activeQ <= cfgSpareEn & ~cfgBad;
    end
  end

  assign cfgErr = cfgErrQ;
  assign active = activeQ;

  // R3: a flagged configuration never leaves sparing active
  a_r3_err_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cfgErrQ |-> !activeQ);

  // ---------------- per-module error counters ----------------
  logic [NMOD-1:0] over;

  for (genvar m = 0; m < NMOD; m++) begin : g_cnt
    localparam bit IS_PRIM = ((m % SLOTS) != SLOTS - 1);
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) cntQ <= '0;
      else if (errValid && (errMod == MOD_W'(m)) && (cntQ != {CNT_W{1'b1}}))
        cntQ <= cntQ + 1'b1;
    end

    assign over[m] = IS_PRIM && popMask[m] && (cntQ > cfgThresh);

    // R4: saturating count
    a_r4_cnt_saturates: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ == {CNT_W{1'b1}}) |=> (cntQ == {CNT_W{1'b1}}));
  end

  logic [MOD_W-1:0] hitMod;

  always_comb begin
    hitMod = '0;
    for (int m = NMOD - 1; m >= 0; m--)
      if (over[m]) hitMod = MOD_W'(m);
  end

  assign hit = |over;

  // ---------------- copy setup ----------------
  logic [SLOT_W-1:0] hitSlot;
  logic [NUM_CH-1:0] srcNext;
  logic [SZ_W-1:0]   lenSz;
  logic [ADDR_W-1:0] lastNext;

  always_comb begin
    hitSlot = SLOT_W'(int'(hitMod) % SLOTS);
    srcNext = '0;
    lenSz   = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      srcNext[c] = popMask[c*SLOTS + int'(hitSlot)];
      if (srcNext[c] && (sizeCodes[(c*SLOTS + int'(hitSlot))*SZ_W +: SZ_W] > lenSz))
        lenSz = sizeCodes[(c*SLOTS + int'(hitSlot))*SZ_W +: SZ_W];
    end
    lastNext = ADDR_W'((1 << lenSz) - 1);
  end

  logic [MOD_W-1:0]  failModQ;
  logic [SLOT_W-1:0] failSlotQ;
  logic [NUM_CH-1:0] srcMaskQ;
  logic [ADDR_W-1:0] lastAddrQ, copyAddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failModQ  <= '0;
      failSlotQ <= '0;
      srcMaskQ  <= '0;
      lastAddrQ <= '0;
      copyAddrQ <= '0;
    end else if (strb.startCopy) begin
      failModQ  <= hitMod;
      failSlotQ <= hitSlot;
      srcMaskQ  <= srcNext;
      lastAddrQ <= lastNext;
      copyAddrQ <= '0;
    end else if (strb.copyStep) begin
      copyAddrQ <= copyAddrQ + 1'b1;
    end
  end

  assign copyLast    = (copyAddrQ == lastAddrQ);
  assign copyAddr    = copyAddrQ;
  assign copySrcMask = srcMaskQ;
  assign failMod     = failModQ;

  // R5: one word per granted step
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.copyStep |=> (copyAddrQ == ADDR_W'($past(copyAddrQ) + 1'b1)));

  // R5: the copy never runs past its length
  a_r5_addr_bound: assert property (@(posedge clk) disable iff (!rstN)
    strb.copying |-> (copyAddrQ <= lastAddrQ));

  // R8: the failed index is frozen once chosen
  a_r8_fail_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (strb.copying || strb.spared) |=> $stable(failModQ));

  // ---------------- address steering ----------------
  int reqChI, reqSlotI, spareIdx;
  logic hitFail;

  always_comb begin
    reqChI   = int'(reqMod) / SLOTS;
    reqSlotI = int'(reqMod) % SLOTS;
    spareIdx = reqChI * SLOTS + SLOTS - 1;
    hitFail  = (reqSlotI == int'(failSlotQ)) && (reqChI < NUM_CH);
    reqHole  = reqValid && activeQ && (reqSlotI == SLOTS - 1);
    reqPhysMod   = (strb.spared && hitFail) ? MOD_W'(spareIdx) : reqMod;
    reqMirrorMod = MOD_W'(spareIdx);
    reqMirror    = reqValid && reqWrite && strb.copying && hitFail &&
                   (reqChI < NUM_CH) && srcMaskQ[reqChI % NUM_CH];
  end

  // R6: mirroring only while copying, only for writes
  a_r6_mirror_window: assert property (@(posedge clk) disable iff (!rstN)
    reqMirror |-> (strb.copying && reqWrite));

  // R2: a hidden slot is never a mirror source
  a_r2_hole_no_mirror: assert property (@(posedge clk) disable iff (!rstN)
    reqHole |-> !reqMirror);

endmodule

// File: rtl/spare_failover.sv
module spare_failover
  import spare_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int SLOTS  = 3,
  parameter int CNT_W  = 4,
  parameter int SZ_W   = 3,
  localparam int NMOD   = NUM_CH * SLOTS,
  localparam int MOD_W  = (NMOD > 1) ? $clog2(NMOD) : 1,
  localparam int ADDR_W = (1 << SZ_W) - 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgSpareEn,
  input  logic [CNT_W-1:0]     cfgThresh,
  input  logic [NMOD-1:0]      popMask,
  input  logic [NMOD*SZ_W-1:0] sizeCodes,
  input  logic                 errValid,
  input  logic [MOD_W-1:0]     errMod,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [MOD_W-1:0]     reqMod,
  output logic [MOD_W-1:0]     reqPhysMod,
  output logic                 reqHole,
  output logic                 reqMirror,
  output logic [MOD_W-1:0]     reqMirrorMod,
  output logic                 copyReq,
  input  logic                 copyGnt,
  output logic [ADDR_W-1:0]    copyAddr,
  output logic [NUM_CH-1:0]    copySrcMask,
  output logic [1:0]           stateOut,
  output logic [MOD_W-1:0]     failMod,
  output logic                 cfgErr
);

  ctrlStrobe_t strb;
  logic active, hit, copyLast;

  spare_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .active   (active),
    .hit      (hit),
    .copyGnt  (copyGnt),
    .copyLast (copyLast),
    .strb     (strb),
    .stateOut (stateOut)
  );

  spare_dp #(
    .NUM_CH (NUM_CH),
    .SLOTS  (SLOTS),
    .CNT_W  (CNT_W),
    .SZ_W   (SZ_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgSpareEn   (cfgSpareEn),
    .cfgThresh    (cfgThresh),
    .popMask      (popMask),
    .sizeCodes    (sizeCodes),
    .errValid     (errValid),
    .errMod       (errMod),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqMod       (reqMod),
    .reqPhysMod   (reqPhysMod),
    .reqHole      (reqHole),
    .reqMirror    (reqMirror),
    .reqMirrorMod (reqMirrorMod),
    .copyAddr     (copyAddr),
    .copySrcMask  (copySrcMask),
    .failMod      (failMod),
    .cfgErr       (cfgErr),
    .active       (active),
    .hit          (hit),
    .copyLast     (copyLast)
  );

  assign copyReq = strb.copying;

  // R5: copy requests appear only while copying
  a_r5_req_state: assert property (@(posedge clk) disable iff (!rstN)
    copyReq |-> (stateOut == 2'd1));

endmodule

// File: tb/sim_spare_failover.sv
module sim_spare_failover;

  localparam int PERIOD = 10;
  localparam int NUM_CH = 2;
  localparam int SLOTS  = 3;
  localparam int CNT_W  = 4;
  localparam int SZ_W   = 3;
  localparam int NMOD   = NUM_CH * SLOTS;
  localparam int MOD_W  = $clog2(NMOD);
  localparam int ADDR_W = (1 << SZ_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgSpareEn = 1'b0;
  logic [CNT_W-1:0] cfgThresh = 4'd3;
  logic [NMOD-1:0] popMask = '1;
  logic [NMOD*SZ_W-1:0] sizeCodes = '0;
  logic errValid = 1'b0;
  logic [MOD_W-1:0] errMod = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [MOD_W-1:0] reqMod = '0;
  logic [MOD_W-1:0] reqPhysMod, reqMirrorMod, failMod;
  logic reqHole, reqMirror, copyReq, cfgErr;
  logic copyGnt = 1'b0;
  logic [ADDR_W-1:0] copyAddr;
  logic [NUM_CH-1:0] copySrcMask;
  logic [1:0] stateOut;

  int checks = 0;
  int errors = 0;
  int sz [NMOD];
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  spare_failover u0 (
    .clk(clk), .rstN(rstN), .cfgSpareEn(cfgSpareEn), .cfgThresh(cfgThresh),
    .popMask(popMask), .sizeCodes(sizeCodes), .errValid(errValid), .errMod(errMod),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqMod(reqMod),
    .reqPhysMod(reqPhysMod), .reqHole(reqHole), .reqMirror(reqMirror),
    .reqMirrorMod(reqMirrorMod), .copyReq(copyReq), .copyGnt(copyGnt),
    .copyAddr(copyAddr), .copySrcMask(copySrcMask), .stateOut(stateOut),
    .failMod(failMod), .cfgErr(cfgErr)
  );

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic loadSizes;
    for (int m = 0; m < NMOD; m++) sizeCodes[m*SZ_W +: SZ_W] = SZ_W'(sz[m]);
  endtask

  task automatic doReset;
    rstN = 1'b0;
    repeat (2) tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic errInject(int mod, int n);
    for (int i = 0; i < n; i++) begin
      errValid = 1'b1;
      errMod = MOD_W'(mod);
      tick();
    end
    errValid = 1'b0;
  endtask

  task automatic holeSweep(string tag, bit expectHidden);
    for (int m = 0; m < NMOD; m++) begin
      reqValid = 1'b1; reqWrite = 1'b0; reqMod = MOD_W'(m);
      #1;
      check(tag, int'(reqHole), (expectHidden && (m % SLOTS == SLOTS - 1)) ? 1 : 0);
    end
    reqValid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int grants;
    int len;
    sz = '{3, 4, 5, 2, 5, 5};
    loadSizes();
    @(negedge clk);
    repeat (2) tick();
    // R1: reset values
    check("R1 state", int'(stateOut), 0);
    check("R1 copyReq", int'(copyReq), 0);
    check("R1 copyAddr", int'(copyAddr), 0);
    check("R1 failMod", int'(failMod), 0);
    check("R1 cfgErr", int'(cfgErr), 0);
    rstN = 1'b1;
    tick();

    // R3: reserve in channel 1 too small (code 4 < largest primary 5)
    sz[5] = 4; loadSizes();
    cfgSpareEn = 1'b1;
    tick();
    check("R3 cfgErr set", int'(cfgErr), 1);
    holeSweep("R3 reserve visible on error", 1'b0);
    errInject(1, 6);
    repeat (2) tick();
    check("R3 no start", int'(stateOut), 0);

    // R9: sparing disabled, all visible, no failover
    sz[5] = 5; loadSizes();
    cfgSpareEn = 1'b0;
    doReset();
    check("R9 cfgErr clear", int'(cfgErr), 0);
    holeSweep("R9 all visible", 1'b0);
    errInject(1, 6);
    repeat (2) tick();
    check("R9 no start", int'(stateOut), 0);

    // Main failover with partner present
    cfgSpareEn = 1'b1;
    doReset();
    check("R3 good config", int'(cfgErr), 0);
    holeSweep("R2 reserve hidden", 1'b1);
    for (int m = 0; m < NMOD; m++) begin
      reqValid = 1'b1; reqWrite = 1'b0; reqMod = MOD_W'(m);
      #1;
      check("R7 identity map", int'(reqPhysMod), m);
    end
    reqValid = 1'b0;
    errInject(1, 3);
    tick();
    check("R4 at threshold no start", int'(stateOut), 0);
    errInject(1, 1);
    check("R4 start not yet", int'(stateOut), 0);
    tick();
    check("R4 copying", int'(stateOut), 1);
    check("R4 failMod", int'(failMod), 1);
    check("R5 copyReq", int'(copyReq), 1);
    check("R5 srcMask", int'(copySrcMask), 3);
    check("R5 start addr", int'(copyAddr), 0);

    // R8: another module crosses during the copy
    errInject(3, 5);
    tick();
    check("R8 failMod kept", int'(failMod), 1);
    check("R8 still copying", int'(stateOut), 1);
    check("R8 addr kept", int'(copyAddr), 0);

    // R6: mirror behaviour during copy
    reqValid = 1'b1; reqWrite = 1'b1; reqMod = 3'd4; #1;
    check("R6 partner write mirrored", int'(reqMirror), 1);
    check("R6 partner mirror target", int'(reqMirrorMod), 5);
    reqWrite = 1'b0; reqMod = 3'd1; #1;
    check("R6 read not mirrored", int'(reqMirror), 0);
    check("R7 read stays on failing", int'(reqPhysMod), 1);
    reqWrite = 1'b1; reqMod = 3'd0; #1;
    check("R6 other module not mirrored", int'(reqMirror), 0);
    reqValid = 1'b0; reqWrite = 1'b0;

    // R5: copy walk, 2^5 words, with idle holes in the grants
    len = 1 << 5;
    for (int k = 0; k < len; k++) begin
      if (k % 3 == 1) begin
        copyGnt = 1'b0; #1;
        check("R5 hold without grant", int'(copyAddr), k);
        tick();
      end
      copyGnt = 1'b1; #1;
      check("R5 copy addr", int'(copyAddr), k);
      if (k == len - 1) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqMod = 3'd1; #1;
        check("R6 write at final grant mirrored", int'(reqMirror), 1);
        check("R6 final mirror target", int'(reqMirrorMod), 2);
        check("R7 not yet spared", int'(stateOut), 1);
      end
      tick();
    end
    copyGnt = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    check("R7 spared", int'(stateOut), 2);
    check("R7 copyReq low", int'(copyReq), 0);
    for (int m = 0; m < NMOD; m++) begin
      reqValid = 1'b1; reqWrite = 1'b1; reqMod = MOD_W'(m);
      #1;
      check("R7 remap", int'(reqPhysMod),
            (m % SLOTS == 1) ? (m / SLOTS) * SLOTS + SLOTS - 1 : m);
      check("R6 no mirror after remap", int'(reqMirror), 0);
    end
    reqValid = 1'b0; reqWrite = 1'b0;
    errInject(0, 6);
    repeat (3) tick();
    check("R8 one shot", int'(stateOut), 2);
    check("R8 no copy req", int'(copyReq), 0);
    check("R8 failMod unchanged", int'(failMod), 1);

    // R5: no partner in channel 1, length from module 1 alone (2^4)
    popMask = 6'b101111;
    doReset();
    errInject(1, 4);
    tick();
    check("R4 copying no partner", int'(stateOut), 1);
    check("R5 srcMask single", int'(copySrcMask), 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqMod = 3'd4; #1;
    check("R6 absent partner not mirrored", int'(reqMirror), 0);
    reqValid = 1'b0; reqWrite = 1'b0;
    grants = 0;
    copyGnt = 1'b1;
    while (stateOut != 2'd2 && grants < 200) begin
      tick();
      grants++;
    end
    copyGnt = 1'b0;
    check("R5 copy length", grants, 16);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule